// File: doc/BRIEF.md
# Multiplexed External Bus Controller with Per-Cycle Width

This block connects a 16-bit core to external memory over a multiplexed address/data bus. The core places one request at a time: a word address, a two-bit byte mask, write data, and a flag that marks instruction fetches. The request is held until a single-cycle acknowledge returns, which carries read data for reads. Each bus cycle steps through four phases, one state per clock: address, strobe, optional wait, and data. The address is driven onto the shared lines first. Read or write strobes become active only in the data phase.

The bus width is set by two configuration bits. The cycle can be fixed at 16 bits, fixed at 8 bits, or chosen per cycle by sampling a width pin when the request is accepted. On an 8-bit bus, a two-byte request becomes two byte cycles. The address strobe can behave as a latch pulse or as an active-low address-valid level. The second strobe pin can carry a high-byte enable, with a combined write strobe on the first pin, or the two pins can act as separate low-byte and high-byte write strobes. A ready input extends cycles with wait states, up to a programmable limit.

Top module: `xbus_ctrl`

## Requirements
- R1: `cfg_wmode` selects the width: 2'b01 gives every cycle 16 bits, 2'b10 gives every cycle 8 bits, and 2'b11 samples `bus_wide` when a request starts (0 = 8-bit, 1 = 16-bit). With no waits, a request takes 1 + 3·(byte cycles) clocks from the first edge that sees `req_valid` to the edge that raises `req_ack`.
- R2: With `cfg_wmode` = 2'b00, `cfg_illegal` is 1. In that state no bus cycle starts: the strobe, RD and WR pins stay inactive and no acknowledge is given.
- R3: A ready sample of 0 at the end of the strobe phase or a wait state adds one wait state. The first rising edge that finds `bus_ready` high moves the cycle to the data phase.
- R4: At most `cfg_max_wait` wait states are added per byte/word cycle. When `cfg_max_wait` is 0, ready is ignored.
- R5: In byte-enable mode (`cfg_split_wr`=0), a 16-bit cycle encodes lanes on AD[0] and `bus_hi_n` through the whole cycle. Low byte only: A0=0, `bus_hi_n`=1. High byte only: A0=1, `bus_hi_n`=0. Both bytes: A0=0, `bus_hi_n`=0.
- R6: In split-write mode (`cfg_split_wr`=1), `bus_wr_lo_n` goes low only when the even byte is written, and `bus_hi_n` goes low only when the odd byte is written. Neither is low during reads.
- R7: In byte-enable mode, `bus_wr_lo_n` goes low for one data phase per byte/word cycle on every write, whatever the mask. `bus_hi_n` stays high on 8-bit cycles.
- R8: With `cfg_adv`=0, `bus_strobe` is high only in the address phase, once per byte/word cycle. With `cfg_adv`=1, `bus_strobe` is low from the address phase through the data phase and high again when the acknowledge is given.
- R9: `bus_fetch` is high throughout a read cycle whose request sets `req_fetch`. It is low for data reads and writes.
- R10: On an 8-bit bus, a mask of 2'b11 runs two byte cycles, even byte (A0=0) first and then odd byte (A0=1). It is acknowledged once, after both.
- R11: RD and WR never go low together. `req_rdata` carries the read bytes in their lanes, with lanes outside the mask returned as zero.
- R12: After reset, `req_ack` is 0, `bus_rd_n`, `bus_wr_lo_n` and `bus_hi_n` are 1, `bus_ad_oe` is 0, and the strobe is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wmode | input | 2 | Width mode select |
| cfg_adv | input | 1 | 1 = address-valid strobe style, 0 = latch pulse |
| cfg_split_wr | input | 1 | 1 = separate low/high write strobes |
| cfg_max_wait | input | WAIT_W | Wait-state limit per cycle |
| cfg_illegal | output | 1 | Width mode setting is invalid |
| req_valid | input | 1 | Request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_waddr | input | 15 | Word address |
| req_be | input | 2 | Byte mask, bit 0 = even byte |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid with ack |
| bus_ad_out | output | 16 | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Drive enable for AD |
| bus_ad_in | input | 16 | Multiplexed data in |
| bus_wide | input | 1 | Width select pin |
| bus_ready | input | 1 | Ready, low extends cycle |
| bus_strobe | output | 1 | Address latch / valid strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_lo_n | output | 1 | Write or low-byte write strobe |
| bus_hi_n | output | 1 | High-byte enable or high-byte write strobe |
| bus_fetch | output | 1 | Instruction fetch indicator |

## Verification
The bench builds the block with its default `WAIT_W` of 3, so wait limits of 0, 2, 3 and 7 can all be set. This covers the limit taking effect while ready is held low, a limit of zero that ignores ready, and a limit high enough that a ready rise ends the wait. A byte-addressed memory model in the bench decodes the lane pins and the address latched from AD. The model responds in whichever width the bench expects, so any wrong width choice, lane decode or byte order shows up in the data read back.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int DATA_W = 16;
  localparam int WADDR_W = 15;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_STRB, ST_WAIT, ST_DATA, ST_DONE
  } xbus_state_e;

  // width mode: 01 -> 16-bit, 10 -> 8-bit, 11 -> pin decides, 00 -> invalid
  function automatic logic width_pick(input logic [1:0] mode, input logic pin);
    case (mode)
      2'b11:   return pin;
      2'b01:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic mode_invalid(input logic [1:0] mode);
    return (mode == 2'b00);
  endfunction

  // A0 on a 16-bit cycle: set only when the odd byte alone is accessed
  function automatic logic wide_a0(input logic [1:0] be);
    return (be == 2'b10);
  endfunction

  // merge sampled AD into the read-data register
  function automatic logic [DATA_W-1:0] lane_merge(
      input logic [DATA_W-1:0] acc, input logic [DATA_W-1:0] ad,
      input logic wide, input logic [1:0] be, input logic hi_byte);
    logic [DATA_W-1:0] r;
    r = acc;
    if (wide) begin
      r[7:0]  = be[0] ? ad[7:0]  : 8'h00;
      r[15:8] = be[1] ? ad[15:8] : 8'h00;
    end else if (hi_byte) begin
      r[15:8] = ad[7:0];
    end else begin
      r[7:0] = ad[7:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/xbus_width_sel.sv
module xbus_width_sel
  import xbus_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       pin_i,
  output logic       wide_o,
  output logic       bad_o
);
  always_comb begin
    wide_o = width_pick(mode_i, pin_i);
    bad_o  = mode_invalid(mode_i);
  end
endmodule

// File: rtl/xbus_wait_ctr.sv
module xbus_wait_ctr #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [WAIT_W-1:0] limit_i,
  output logic              cap_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cap_o = (cnt_q >= limit_i);

  // R4: a wait state is only added while under the limit
  assert_wait_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/xbus_strobe_enc.sv
module xbus_strobe_enc (
  input  logic ph_addr_i,
  input  logic ph_active_i,
  input  logic ph_data_i,
  input  logic is_write_i,
  input  logic is_fetch_i,
  input  logic adv_mode_i,
  input  logic split_i,
  input  logic wide_i,
  input  logic lo_sel_i,
  input  logic hi_sel_i,
  output logic strobe_o,
  output logic rd_n_o,
  output logic wr_lo_n_o,
  output logic hi_n_o,
  output logic fetch_o
);
  logic wr_ph;
  assign wr_ph = ph_data_i & is_write_i;

  always_comb begin
    strobe_o = adv_mode_i ? ~ph_active_i : ph_addr_i;
    rd_n_o   = ~(ph_data_i & ~is_write_i);
    fetch_o  = ph_active_i & is_fetch_i & ~is_write_i;
    if (split_i) begin
      wr_lo_n_o = ~(wr_ph & lo_sel_i);
      hi_n_o    = ~(wr_ph & hi_sel_i);
    end else begin
      wr_lo_n_o = ~wr_ph;
      hi_n_o    = ~(ph_active_i & wide_i & hi_sel_i);
    end
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_wmode,
  input  logic               cfg_adv,
  input  logic               cfg_split_wr,
  input  logic [WAIT_W-1:0]  cfg_max_wait,
  output logic               cfg_illegal,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_fetch,
  input  logic [WADDR_W-1:0] req_waddr,
  input  logic [1:0]         req_be,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ack,
  output logic [DATA_W-1:0]  req_rdata,
  output logic [DATA_W-1:0]  bus_ad_out,
  output logic               bus_ad_oe,
  input  logic [DATA_W-1:0]  bus_ad_in,
  input  logic               bus_wide,
  input  logic               bus_ready,
  output logic               bus_strobe,
  output logic               bus_rd_n,
  output logic               bus_wr_lo_n,
  output logic               bus_hi_n,
  output logic               bus_fetch
);
  xbus_state_e state_q, state_d;
  logic               wide_q, write_q, fetch_q, byte_hi_q, two_q;
  logic [WADDR_W-1:0] waddr_q;
  logic [1:0]         be_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;

  // named internal events
  logic pick_wide, mode_bad, start_cyc, wait_step, wait_cap, wait_clr;
  logic ph_addr, ph_active, ph_data, cyc_a0, lo_sel, hi_sel, data_end;

  xbus_width_sel u_wsel (
    .mode_i (cfg_wmode),
    .pin_i  (bus_wide),
    .wide_o (pick_wide),
    .bad_o  (mode_bad)
  );

  assign cfg_illegal = mode_bad;
  assign start_cyc   = (state_q == ST_IDLE) && req_valid && !mode_bad;
  assign ph_addr     = (state_q == ST_ADDR);
  assign ph_data     = (state_q == ST_DATA);
  assign ph_active   = ph_addr || (state_q == ST_STRB) || (state_q == ST_WAIT) || ph_data;
  assign wait_clr    = ph_addr;
  assign data_end    = ph_data;

  assign cyc_a0 = wide_q ? wide_a0(be_q) : byte_hi_q;
  assign lo_sel = wide_q ? be_q[0] : ~byte_hi_q;
  assign hi_sel = wide_q ? be_q[1] : byte_hi_q;

  always_comb begin
    state_d   = state_q;
    wait_step = 1'b0;
    case (state_q)
      ST_IDLE: if (start_cyc) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_STRB;
      ST_STRB: begin
        if (!bus_ready && !wait_cap) begin
          state_d   = ST_WAIT;
          wait_step = 1'b1;
        end else begin
          state_d = ST_DATA;
        end
      end
      ST_WAIT: begin
        if (bus_ready || wait_cap) state_d = ST_DATA;
        else wait_step = 1'b1;
      end
      ST_DATA: state_d = two_q ? ST_ADDR : ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  xbus_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (wait_clr),
    .step_i  (wait_step),
    .limit_i (cfg_max_wait),
    .cap_o   (wait_cap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wide_q    <= 1'b0;
      write_q   <= 1'b0;
      fetch_q   <= 1'b0;
      byte_hi_q <= 1'b0;
      two_q     <= 1'b0;
      waddr_q   <= '0;
      be_q      <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_cyc) begin
        wide_q    <= pick_wide;
        write_q   <= req_write;
        fetch_q   <= req_fetch;
        waddr_q   <= req_waddr;
        be_q      <= req_be;
        wdata_q   <= req_wdata;
        rdata_q   <= '0;
        two_q     <= !pick_wide && (req_be == 2'b11);
        byte_hi_q <= !pick_wide && (req_be == 2'b10);
      end else if (data_end) begin
        if (!write_q)
          rdata_q <= lane_merge(rdata_q, bus_ad_in, wide_q, be_q, byte_hi_q);
        if (two_q) begin
          two_q     <= 1'b0;
          byte_hi_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    bus_ad_out = {waddr_q, cyc_a0};
    if (ph_data && write_q)
      bus_ad_out = wide_q ? wdata_q
                          : {8'h00, (byte_hi_q ? wdata_q[15:8] : wdata_q[7:0])};
  end
  assign bus_ad_oe = ph_active && !(ph_data && !write_q);
  assign req_ack   = (state_q == ST_DONE);
  assign req_rdata = rdata_q;

  xbus_strobe_enc u_enc (
    .ph_addr_i   (ph_addr),
    .ph_active_i (ph_active),
    .ph_data_i   (ph_data),
    .is_write_i  (write_q),
    .is_fetch_i  (fetch_q),
    .adv_mode_i  (cfg_adv),
    .split_i     (cfg_split_wr),
    .wide_i      (wide_q),
    .lo_sel_i    (lo_sel),
    .hi_sel_i    (hi_sel),
    .strobe_o    (bus_strobe),
    .rd_n_o      (bus_rd_n),
    .wr_lo_n_o   (bus_wr_lo_n),
    .hi_n_o      (bus_hi_n),
    .fetch_o     (bus_fetch)
  );

  // R2: an invalid width setting keeps the controller idle
  assert_illegal_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_illegal && state_q == ST_IDLE) |=> (state_q == ST_IDLE));
  // R10: one acknowledge per request, never two in a row
  assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);
  // R9: fetch indicator never accompanies a write strobe
  assert_fetch_not_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fetch |-> bus_wr_lo_n);
  // R8: in valid-style mode the strobe is held while reading
  assert_adv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_adv && !bus_rd_n) |-> !bus_strobe);
  // R11: read and write strobes are exclusive
  assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_lo_n));
endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  cfg_wmode = 2'b01;
  logic        cfg_adv = 0, cfg_split_wr = 0;
  logic [2:0]  cfg_max_wait = 3'd3;
  logic        cfg_illegal;
  logic        req_valid = 0, req_write = 0, req_fetch = 0;
  logic [14:0] req_waddr = '0;
  logic [1:0]  req_be = 2'b11;
  logic [15:0] req_wdata = '0;
  logic        req_ack;
  logic [15:0] req_rdata, bus_ad_out, bus_ad_in;
  logic        bus_ad_oe, bus_wide = 0, bus_ready = 1;
  logic        bus_strobe, bus_rd_n, bus_wr_lo_n, bus_hi_n, bus_fetch;

  always #5 clk = ~clk;

  xbus_ctrl u_dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0] mem [0:255];
  logic [7:0] sh  [0:255];
  logic [7:0] la = 0;
  bit cur_wide = 1;
  int n_rd, n_lo, n_hi, n_fr, n_str, lat;
  logic [15:0] first_addr, last_addr;
  logic first_hi, got_first, str_at_ack;

  typedef struct { bit rd; logic [15:0] data; int lat; string tag; } exp_t;
  exp_t exp_q[$];

  assign bus_ad_in = cur_wide ? {mem[{la[7:1],1'b1}], mem[{la[7:1],1'b0}]}
                              : {8'h00, mem[la]};

  function automatic int lat_of(int nbytes, int waits);
    return 1 + 3*nbytes + waits;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor + memory model
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic act_str;
      act_str = cfg_adv ? !bus_strobe : bus_strobe;
      if (req_valid) lat++; else lat = 0;
      if (!bus_rd_n) n_rd++;
      if (!bus_wr_lo_n) n_lo++;
      if (!bus_hi_n) n_hi++;
      if (bus_fetch && !bus_rd_n) n_fr++;
      if (act_str) n_str++;
      if (act_str && bus_ad_oe && bus_rd_n && bus_wr_lo_n && (!cfg_split_wr || bus_hi_n)) begin
        if (!got_first) begin first_addr = bus_ad_out; first_hi = bus_hi_n; got_first = 1; end
        last_addr = bus_ad_out;
        la = bus_ad_out[7:0];
      end
      if (cfg_split_wr) begin
        if (!bus_wr_lo_n) mem[la] = bus_ad_out[7:0];
        if (!bus_hi_n) begin
          if (cur_wide) mem[{la[7:1],1'b1}] = bus_ad_out[15:8];
          else mem[la] = bus_ad_out[7:0];
        end
      end else if (!bus_wr_lo_n) begin
        if (cur_wide) begin
          if (!la[0]) mem[la] = bus_ad_out[7:0];
          if (!bus_hi_n) mem[{la[7:1],1'b1}] = bus_ad_out[15:8];
        end else mem[la] = bus_ad_out[7:0];
      end
      if (req_ack) begin
        str_at_ack = bus_strobe;
        if (exp_q.size() == 0) chk(0, "R2 unexpected ack", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(lat == e.lat, {e.tag, " latency"}, lat, e.lat);
          if (e.rd) chk(req_rdata == e.data, {e.tag, " rdata"}, req_rdata, e.data);
        end
        lat = 0;
      end
    end
  end

  task automatic run(input bit wr, input bit fe, input logic [15:0] a,
                     input logic [1:0] be, input logic [15:0] wd, input int el, input string tag);
    exp_t e;
    logic [7:0] b;
    b = {a[7:1], 1'b0};
    if (wr) begin
      if (be[0]) sh[b] = wd[7:0];
      if (be[1]) sh[b+8'd1] = wd[15:8];
    end
    e.rd = !wr; e.lat = el; e.tag = tag;
    e.data = {be[1] ? sh[b+8'd1] : 8'h00, be[0] ? sh[b] : 8'h00};
    exp_q.push_back(e);
    @(negedge clk);
    n_rd = 0; n_lo = 0; n_hi = 0; n_fr = 0; n_str = 0; got_first = 0;
    req_valid = 1; req_write = wr; req_fetch = fe; req_waddr = a[15:1];
    req_be = be; req_wdata = wd;
    do @(negedge clk); while (!req_ack);
    req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = i[7:0] ^ 8'hC3; sh[i] = i[7:0] ^ 8'hC3; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk(!req_ack && bus_rd_n && bus_wr_lo_n && bus_hi_n && !bus_ad_oe && !bus_strobe,
        "R12 reset state", {bus_rd_n, bus_wr_lo_n, bus_hi_n, bus_ad_oe, bus_strobe}, 5'b11100);

    // 16-bit forced, byte-enable, latch pulse
    cur_wide = 1;
    run(1, 0, 16'h0010, 2'b11, 16'hBEEF, lat_of(1, 0), "R1 wide write");
    chk(n_lo == 1, "R7 one WR per write", n_lo, 1);
    chk(n_hi == 3, "R5 BHE both bytes", n_hi, 3);
    chk(first_addr == 16'h0010, "R5 A0 both bytes", first_addr, 16'h0010);
    run(0, 0, 16'h0010, 2'b11, 0, lat_of(1, 0), "R11 wide read");
    chk(n_rd == 1 && n_lo == 0, "R11 RD only in data phase", n_rd, 1);
    chk(n_str == 1, "R8 latch pulse once", n_str, 1);
    run(1, 0, 16'h0021, 2'b10, 16'h7700, lat_of(1, 0), "R5 high byte write");
    chk(first_addr == 16'h0021 && first_hi == 0, "R5 high only A0=1 BHE=0",
        {first_addr, 3'b0, first_hi}, {16'h0021, 4'h0});
    run(0, 0, 16'h0020, 2'b01, 0, lat_of(1, 0), "R11 low lane read");
    chk(first_addr == 16'h0020 && first_hi == 1, "R5 low only A0=0 BHE=1",
        {first_addr, 3'b0, first_hi}, {16'h0020, 4'h1});
    run(0, 0, 16'h0020, 2'b11, 0, lat_of(1, 0), "R5 merged word");

    // split-write strobes
    cfg_split_wr = 1;
    run(1, 0, 16'h0030, 2'b01, 16'h0055, lat_of(1, 0), "R6 even write");
    chk(n_lo == 1 && n_hi == 0, "R6 even byte uses WRL", {n_lo[3:0], n_hi[3:0]}, 8'h10);
    run(1, 0, 16'h0031, 2'b10, 16'h6600, lat_of(1, 0), "R6 odd write");
    chk(n_lo == 0 && n_hi == 1, "R6 odd byte uses WRH", {n_lo[3:0], n_hi[3:0]}, 8'h01);
    run(0, 0, 16'h0030, 2'b11, 0, lat_of(1, 0), "R6 readback");
    chk(n_hi == 0 && n_lo == 0, "R6 no write strobes on read", n_hi + n_lo, 0);
    cfg_split_wr = 0;

    // wait states
    bus_ready = 0; cfg_max_wait = 3'd3;
    run(0, 0, 16'h0010, 2'b11, 0, lat_of(1, 3), "R4 limit 3");
    cfg_max_wait = 3'd0;
    run(0, 0, 16'h0010, 2'b11, 0, lat_of(1, 0), "R4 limit 0 ignores ready");
    cfg_max_wait = 3'd7;
    fork
      run(0, 0, 16'h0010, 2'b11, 0, lat_of(1, 1), "R3 ready rise ends wait");
      begin repeat (4) @(negedge clk); bus_ready = 1; end
    join
    chk(n_rd == 1, "R3 data phase single", n_rd, 1);

    // 8-bit forced
    cfg_wmode = 2'b10; cur_wide = 0; bus_ready = 1;
    run(1, 0, 16'h0040, 2'b11, 16'hA1B2, lat_of(2, 0), "R10 byte pair write");
    chk(n_lo == 2 && n_hi == 0, "R7 8-bit WR twice no BHE", {n_lo[3:0], n_hi[3:0]}, 8'h20);
    run(0, 0, 16'h0040, 2'b11, 0, lat_of(2, 0), "R10 byte pair read");
    chk(first_addr == 16'h0040 && last_addr == 16'h0041, "R10 even byte first",
        {first_addr, last_addr}, {16'h0040, 16'h0041});
    run(0, 0, 16'h0040, 2'b10, 0, lat_of(1, 0), "R1 8-bit single odd");
    chk(first_addr == 16'h0041, "R10 odd single A0", first_addr, 16'h0041);
    bus_ready = 0; cfg_max_wait = 3'd2;
    run(0, 0, 16'h0040, 2'b11, 0, lat_of(2, 4), "R4 limit per byte cycle");
    bus_ready = 1; cfg_split_wr = 1;
    run(1, 0, 16'h0050, 2'b11, 16'h1357, lat_of(2, 0), "R6 8-bit split write");
    chk(n_lo == 1 && n_hi == 1, "R6 8-bit WRL then WRH", {n_lo[3:0], n_hi[3:0]}, 8'h11);
    run(0, 0, 16'h0050, 2'b11, 0, lat_of(2, 0), "R6 8-bit split readback");
    cfg_split_wr = 0;

    // pin-selected width
    cfg_wmode = 2'b11; bus_wide = 0; cur_wide = 0;
    run(0, 0, 16'h0010, 2'b11, 0, lat_of(2, 0), "R1 pin low 8-bit");
    bus_wide = 1; cur_wide = 1;
    run(0, 0, 16'h0010, 2'b11, 0, lat_of(1, 0), "R1 pin high 16-bit");

    // address-valid style and fetch
    cfg_wmode = 2'b01; cfg_adv = 1;
    run(0, 1, 16'h0010, 2'b11, 0, lat_of(1, 0), "R9 fetch read");
    chk(n_str == 3, "R8 valid held through cycle", n_str, 3);
    chk(str_at_ack == 1, "R8 valid released at end", str_at_ack, 1);
    chk(n_fr == 1, "R9 fetch high during fetch", n_fr, 1);
    run(0, 0, 16'h0010, 2'b11, 0, lat_of(1, 0), "R9 data read");
    chk(n_fr == 0, "R9 fetch low on data read", n_fr, 0);
    cfg_adv = 0;

    // invalid width mode
    cfg_wmode = 2'b00;
    @(negedge clk);
    chk(cfg_illegal == 1, "R2 flag", cfg_illegal, 1);
    n_rd = 0; n_lo = 0; n_str = 0; n_hi = 0;
    req_valid = 1; req_write = 1;
    repeat (12) @(negedge clk);
    chk(n_rd + n_lo + n_str + n_hi == 0, "R2 no bus activity", n_rd + n_lo + n_str + n_hi, 0);
    req_valid = 0;
    cfg_wmode = 2'b01;
    @(negedge clk);
    chk(cfg_illegal == 0, "R2 flag clears", cfg_illegal, 0);
    chk(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule